// File: doc/BRIEF.md
# SCSI Selection Command Sequencer

This block carries out the selection step of a SCSI initiator controller. A command strobe selects one of four selection variants. The sequencer checks that the addressed target answers. It then takes the variant's message bytes from the controller's data FIFO and checks the identify byte. Next it sends the command descriptor bytes to the target-response interface. These come either from the FIFO or from a DMA buffer read port. Last, it records the outcome in the status, interrupt-cause and step fields and sets the bus phase that follows.

The surrounding controller owns the FIFO storage, the DMA buffer and the target model. The sequencer pops or flushes the FIFO and reads the buffer one byte per cycle at byte offsets counted from zero. It passes each command byte on with a last-byte marker and waits for one response code. Bus arbitration and electrical timing are not modelled.

The state machine has six states. In IDLE it waits for a command. PROBE tests whether the target is present. MSG pops message bytes. IDENT judges the identify byte. CMD streams the command bytes. RESP waits for the target's answer. The transitions are:
- IDLE to PROBE when a command is accepted.
- PROBE to IDLE when the target is absent.
- PROBE to CMD for a variant with no message bytes.
- PROBE to MSG otherwise.
- MSG to IDENT after the last message byte.
- IDENT to IDLE on a rejected identify byte, or for the stop variant.
- IDENT to CMD otherwise.
- CMD to RESP after the last command byte.
- RESP to IDLE on a response.

Top module: `selseq_top`

## Requirements
- R1: `busy` is high in every cycle after a command is accepted until the cycle in which the result is written. A `cmd_valid` pulse while `busy` is high has no effect. Accepting a command clears `irq`, the three cause flags and the terminal-count flag, and sets `step` to 0.
- R2: `cmd_kind` selects the variant: 0 takes no message bytes, 1 (with attention) and 2 (with attention and stop) take one, and 3 (attention, three bytes) takes three. Message bytes are popped from the FIFO and are never sent as command bytes. While message bytes are being fetched, the phase shows message-out (6).
- R3: The first message byte is accepted only if bits 2:0 are 0 and bits 7:3 equal 0x80 or 0xC0 (written as a full byte). Otherwise the selection fails with a disconnect: `irq` and `cause_dis` are set, `step` is 0, `fifo_flush` pulses, `connected` is 0 and no command byte is sent.
- R4: If `tgt_present` is low when the target is probed, the same disconnect result occurs, without any message byte being popped.
- R5: Variant 2 stops after its identify byte. The phase becomes message-out (6), with `irq`, `cause_fc`, `cause_bs`, `step` 1 and `connected` 1. FIFO bytes past the identify byte stay in the FIFO.
- R6: Without DMA, the command bytes are all bytes left in the FIFO after the message bytes, sent in FIFO order. `cmd_out_last` marks the final one.
- R7: With DMA, the command length is `cnt_lo + 256*cnt_mid`, and a count of 0 means 65536. Bytes are read at `dma_addr` 0, 1, 2 and onward. The last byte carries `cmd_out_last` and sets the terminal-count flag (status bit 4).
- R8: `tgt_resp` code 0 gives phase status (3), code 1 gives data-in (1) and code 2 gives data-out (0). Each of these sets `irq`, `cause_fc`, `cause_bs`, `step` 4 and `connected` 1.
- R9: `tgt_resp` code 3 is a failed selection and gives the disconnect result of R3.
- R10: `stat_o` holds the phase in bits 2:0, the terminal-count flag in bit 4 and `irq` in bit 7. All other bits are 0.
- R11: After reset, `busy`, `irq`, the cause flags, `step`, `stat_o` and `connected` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Selection command strobe |
| cmd_kind | input | 2 | Selection variant, 0 to 3 |
| cmd_dma | input | 1 | Take command bytes from the DMA buffer |
| cnt_lo | input | 8 | Transfer count, low byte |
| cnt_mid | input | 8 | Transfer count, middle byte |
| sel_id | input | 3 | Target ID from the select-ID register |
| busy | output | 1 | Sequence in progress |
| fifo_count | input | FCNT_W | Bytes held in the data FIFO |
| fifo_rdata | input | 8 | FIFO head byte (show-ahead) |
| fifo_pop | output | 1 | Remove the FIFO head byte |
| fifo_flush | output | 1 | Empty the FIFO |
| dma_addr | output | LEN_W | DMA buffer byte offset |
| dma_rd | output | 1 | DMA buffer read strobe |
| dma_rdata | input | 8 | DMA buffer byte at `dma_addr` |
| tgt_present | input | 1 | Addressed target answers selection |
| tgt_id | output | 3 | ID of the target being selected |
| cmd_out_valid | output | 1 | Command byte to target valid |
| cmd_out_data | output | 8 | Command byte |
| cmd_out_last | output | 1 | Final command byte |
| tgt_resp_valid | input | 1 | Target response available |
| tgt_resp | input | 2 | Target response code |
| irq | output | 1 | Interrupt pending |
| stat_o | output | 8 | Status byte |
| cause_fc | output | 1 | Function-complete cause |
| cause_bs | output | 1 | Bus-service cause |
| cause_dis | output | 1 | Disconnect cause |
| step | output | 3 | Sequence step reached |
| connected | output | 1 | Controller is in the initiator state |

## Verification
The bench builds the block with its default parameters: a 17-bit length path and a 5-bit FIFO level. The 17-bit path lets a zero-count DMA selection run all 65536 bytes end to end. This confirms that the count wraps to the full length and that the last-byte marker and terminal count land on offset 65535. The 5-bit level covers a 16-entry FIFO, which holds the identify byte, the extra stop-variant bytes and a full command block together.

// File: rtl/selseq_pkg.sv
package selseq_pkg;
    localparam int BYTE_W = 8;
    localparam int PH_W   = 3;
    localparam int STEP_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_MSG,
        ST_IDENT,
        ST_CMD,
        ST_RESP
    } seq_state_t;

    typedef enum logic [1:0] {
        K_PLAIN = 2'd0,
        K_ATN   = 2'd1,
        K_STOP  = 2'd2,
        K_ATN3  = 2'd3
    } sel_kind_t;

    localparam logic [PH_W-1:0] PH_DOUT   = 3'd0;
    localparam logic [PH_W-1:0] PH_DIN    = 3'd1;
    localparam logic [PH_W-1:0] PH_CMD    = 3'd2;
    localparam logic [PH_W-1:0] PH_STATUS = 3'd3;
    localparam logic [PH_W-1:0] PH_MOUT   = 3'd6;

    localparam logic [1:0] RSP_STATUS = 2'd0;
    localparam logic [1:0] RSP_DIN    = 2'd1;
    localparam logic [1:0] RSP_DOUT   = 2'd2;

    function automatic logic [1:0] msg_need(input sel_kind_t k);
        unique case (k)
            K_PLAIN: msg_need = 2'd0;
            K_ATN3:  msg_need = 2'd3;
            default: msg_need = 2'd1;
        endcase
    endfunction
endpackage

// File: rtl/selseq_ident_chk.sv
module selseq_ident_chk
    import selseq_pkg::*;
(
    input  logic [BYTE_W-1:0] ident,
    output logic              ok
);
    logic lun_zero;
    logic hdr_good;

    always_comb begin
        lun_zero = (ident[2:0] == 3'b000);
        hdr_good = (ident[7:3] == 5'b10000) || (ident[7:3] == 5'b11000);
        ok       = lun_zero && hdr_good;
    end
endmodule

// File: rtl/selseq_len_calc.sv
module selseq_len_calc
    import selseq_pkg::*;
#(
    parameter int LEN_W = 17
) (
    input  logic [BYTE_W-1:0] lo,
    input  logic [BYTE_W-1:0] mid,
    output logic [LEN_W-1:0]  len
);
    localparam int RAW_W = 2 * BYTE_W;
    localparam logic [LEN_W-1:0] FULL = LEN_W'(1) << RAW_W;

    logic [RAW_W-1:0] raw;

    always_comb begin
        raw = {mid, lo};
        len = (raw == '0) ? FULL : LEN_W'(raw);
    end
endmodule

// File: rtl/selseq_status.sv
module selseq_status
    import selseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ph_we,
    input  logic [PH_W-1:0]   ph_val,
    input  logic              done,
    input  logic              fc_set,
    input  logic              bs_set,
    input  logic              dis_set,
    input  logic [STEP_W-1:0] step_val,
    input  logic              tc_set,
    input  logic              conn_we,
    input  logic              conn_val,
    output logic              irq,
    output logic              fc,
    output logic              bs,
    output logic              dis,
    output logic              tc,
    output logic [STEP_W-1:0] step,
    output logic [PH_W-1:0]   phase,
    output logic              conn
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq   <= 1'b0;
            fc    <= 1'b0;
            bs    <= 1'b0;
            dis   <= 1'b0;
            tc    <= 1'b0;
            step  <= '0;
            phase <= '0;
            conn  <= 1'b0;
        end else begin
            if (clr) begin
                irq  <= 1'b0;
                fc   <= 1'b0;
                bs   <= 1'b0;
                dis  <= 1'b0;
                tc   <= 1'b0;
                step <= '0;
            end
            if (ph_we)   phase <= ph_val;
            if (tc_set)  tc    <= 1'b1;
            if (conn_we) conn  <= conn_val;
            if (done) begin
                irq  <= 1'b1;
                step <= step_val;
                if (fc_set)  fc  <= 1'b1;
                if (bs_set)  bs  <= 1'b1;
                if (dis_set) dis <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/selseq_top.sv
module selseq_top
    import selseq_pkg::*;
#(
    parameter int FCNT_W = 5,
    parameter int LEN_W  = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_kind,
    input  logic              cmd_dma,
    input  logic [7:0]        cnt_lo,
    input  logic [7:0]        cnt_mid,
    input  logic [2:0]        sel_id,
    output logic              busy,
    input  logic [FCNT_W-1:0] fifo_count,
    input  logic [7:0]        fifo_rdata,
    output logic              fifo_pop,
    output logic              fifo_flush,
    output logic [LEN_W-1:0]  dma_addr,
    output logic              dma_rd,
    input  logic [7:0]        dma_rdata,
    input  logic              tgt_present,
    output logic [2:0]        tgt_id,
    output logic              cmd_out_valid,
    output logic [7:0]        cmd_out_data,
    output logic              cmd_out_last,
    input  logic              tgt_resp_valid,
    input  logic [1:0]        tgt_resp,
    output logic              irq,
    output logic [7:0]        stat_o,
    output logic              cause_fc,
    output logic              cause_bs,
    output logic              cause_dis,
    output logic [2:0]        step,
    output logic              connected
);
    localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
    localparam logic [FCNT_W-1:0] FIFO_ONE = FCNT_W'(1);

    seq_state_t        state, nxt;
    sel_kind_t         kind_q;
    logic              dma_q;
    logic [LEN_W-1:0]  len_q, len_in, idx_q;
    logic [1:0]        msg_cnt, need;
    logic [7:0]        id_q;
    logic [2:0]        tid_q;
    logic              id_ok, fifo_any;

    logic              st_clr, ph_we, done, fc_s, bs_s, dis_s, tc_s, conn_we, conn_v;
    logic [PH_W-1:0]   ph_val;
    logic [STEP_W-1:0] step_v;
    logic              tc_q;
    logic [PH_W-1:0]   phase_q;

    selseq_len_calc #(.LEN_W(LEN_W)) u_len (
        .lo (cnt_lo),
        .mid(cnt_mid),
        .len(len_in)
    );

    selseq_ident_chk u_id (
        .ident(id_q),
        .ok   (id_ok)
    );

    selseq_status u_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (st_clr),
        .ph_we   (ph_we),
        .ph_val  (ph_val),
        .done    (done),
        .fc_set  (fc_s),
        .bs_set  (bs_s),
        .dis_set (dis_s),
        .step_val(step_v),
        .tc_set  (tc_s),
        .conn_we (conn_we),
        .conn_val(conn_v),
        .irq     (irq),
        .fc      (cause_fc),
        .bs      (cause_bs),
        .dis     (cause_dis),
        .tc      (tc_q),
        .step    (step),
        .phase   (phase_q),
        .conn    (connected)
    );

    assign need     = msg_need(kind_q);
    assign fifo_any = (fifo_count != '0);
    assign busy     = (state != ST_IDLE);
    assign tgt_id   = tid_q;
    assign dma_addr = idx_q;
    assign stat_o   = {irq, 2'b00, tc_q, 1'b0, phase_q};

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state and strobes
    always_comb begin
        nxt           = state;
        fifo_pop      = 1'b0;
        fifo_flush    = 1'b0;
        dma_rd        = 1'b0;
        cmd_out_valid = 1'b0;
        cmd_out_last  = 1'b0;
        cmd_out_data  = dma_q ? dma_rdata : fifo_rdata;
        st_clr        = 1'b0;
        ph_we         = 1'b0;
        ph_val        = PH_CMD;
        done          = 1'b0;
        fc_s          = 1'b0;
        bs_s          = 1'b0;
        dis_s         = 1'b0;
        tc_s          = 1'b0;
        step_v        = '0;
        conn_we       = 1'b0;
        conn_v        = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    st_clr = 1'b1;
                    nxt    = ST_PROBE;
                end
            end
            ST_PROBE: begin
                if (!tgt_present) begin
                    done = 1'b1; dis_s = 1'b1; fifo_flush = 1'b1;
                    conn_we = 1'b1;
                    nxt = ST_IDLE;
                end else if (need == 2'd0) begin
                    ph_we = 1'b1; ph_val = PH_CMD;
                    nxt = ST_CMD;
                end else begin
                    ph_we = 1'b1; ph_val = PH_MOUT;
                    nxt = ST_MSG;
                end
            end
            ST_MSG: begin
                if (fifo_any) begin
                    fifo_pop = 1'b1;
                    if (msg_cnt == need - 2'd1) nxt = ST_IDENT;
                end
            end
            ST_IDENT: begin
                if (!id_ok) begin
                    done = 1'b1; dis_s = 1'b1; fifo_flush = 1'b1;
                    conn_we = 1'b1;
                    nxt = ST_IDLE;
                end else if (kind_q == K_STOP) begin
                    done = 1'b1; fc_s = 1'b1; bs_s = 1'b1; step_v = 3'd1;
                    conn_we = 1'b1; conn_v = 1'b1;
                    nxt = ST_IDLE;
                end else begin
                    ph_we = 1'b1; ph_val = PH_CMD;
                    nxt = ST_CMD;
                end
            end
            ST_CMD: begin
                if (dma_q) begin
                    dma_rd = 1'b1;
                    cmd_out_valid = 1'b1;
                    if (idx_q == len_q - LEN_ONE) begin
                        cmd_out_last = 1'b1;
                        tc_s = 1'b1;
                        nxt = ST_RESP;
                    end
                end else if (fifo_any) begin
                    fifo_pop = 1'b1;
                    cmd_out_valid = 1'b1;
                    if (fifo_count == FIFO_ONE) begin
                        cmd_out_last = 1'b1;
                        nxt = ST_RESP;
                    end
                end else begin
                    nxt = ST_RESP;
                end
            end
            ST_RESP: begin
                if (tgt_resp_valid) begin
                    nxt = ST_IDLE;
                    done = 1'b1;
                    conn_we = 1'b1;
                    if (tgt_resp == 2'd3) begin
                        dis_s = 1'b1; fifo_flush = 1'b1;
                    end else begin
                        fc_s = 1'b1; bs_s = 1'b1; step_v = 3'd4; conn_v = 1'b1;
                        ph_we = 1'b1;
                        ph_val = (tgt_resp == RSP_DOUT) ? PH_DOUT :
                                 (tgt_resp == RSP_DIN)  ? PH_DIN  : PH_STATUS;
                    end
                end
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Sequence datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            kind_q  <= K_PLAIN;
            dma_q   <= 1'b0;
            len_q   <= '0;
            idx_q   <= '0;
            msg_cnt <= '0;
            id_q    <= '0;
            tid_q   <= '0;
        end else begin
            if (state == ST_IDLE && cmd_valid) begin
                kind_q  <= sel_kind_t'(cmd_kind);
                dma_q   <= cmd_dma;
                len_q   <= len_in;
                tid_q   <= sel_id;
                idx_q   <= '0;
                msg_cnt <= '0;
            end
            if (state == ST_MSG && fifo_pop) begin
                if (msg_cnt == 2'd0) id_q <= fifo_rdata;
                msg_cnt <= msg_cnt + 2'd1;
            end
            if (dma_rd) idx_q <= idx_q + LEN_ONE;
        end
    end
endmodule

// File: rtl/selseq_checker.sv
module selseq_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       fifo_pop,
    input logic       fifo_flush,
    input logic       dma_rd,
    input logic       cmd_out_valid,
    input logic       cmd_out_last,
    input logic       irq,
    input logic [7:0] stat_o,
    input logic       cause_fc,
    input logic       cause_bs,
    input logic       cause_dis,
    input logic [2:0] step,
    input logic       connected
);
    // R1: nothing moves while no sequence runs
    a_r1_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!fifo_pop && !dma_rd && !cmd_out_valid));

    // R6: a byte never comes from both sources
    a_r6_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        !(fifo_pop && dma_rd));

    // R4: a flush always comes with a disconnect result
    a_r4_flush_dis: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_flush |=> (irq && cause_dis && step == 3'd0 && !connected));

    // R3: a disconnect result leaves step 0 and no connection
    a_r3_dis_state: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && cause_dis) |-> (step == 3'd0 && !connected && !cause_fc));

    // R5: stop result is in message-out
    a_r5_stop_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && step == 3'd1) |-> (stat_o[2:0] == 3'd6 && cause_fc && cause_bs && connected));

    // R7: last DMA byte raises terminal count
    a_r7_tc_on_last: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rd && cmd_out_last) |=> stat_o[4]);

    // R8: a completed selection is connected
    a_r8_connected: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && step == 3'd4) |-> (connected && cause_fc && cause_bs));
endmodule

bind selseq_top selseq_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .busy         (busy),
    .fifo_pop     (fifo_pop),
    .fifo_flush   (fifo_flush),
    .dma_rd       (dma_rd),
    .cmd_out_valid(cmd_out_valid),
    .cmd_out_last (cmd_out_last),
    .irq          (irq),
    .stat_o       (stat_o),
    .cause_fc     (cause_fc),
    .cause_bs     (cause_bs),
    .cause_dis    (cause_dis),
    .step         (step),
    .connected    (connected)
);

// File: tb/selseq_top_test.sv
module selseq_top_test;
    localparam int CLK_PERIOD = 10;
    localparam int FCNT_W = 5;
    localparam int LEN_W  = 17;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_kind = 2'd0;
    logic              cmd_dma = 1'b0;
    logic [7:0]        cnt_lo = 8'd0, cnt_mid = 8'd0;
    logic [2:0]        sel_id = 3'd0;
    logic              busy;
    logic [FCNT_W-1:0] fifo_count;
    logic [7:0]        fifo_rdata;
    logic              fifo_pop, fifo_flush;
    logic [LEN_W-1:0]  dma_addr;
    logic              dma_rd;
    logic [7:0]        dma_rdata;
    logic              tgt_present = 1'b1;
    logic [2:0]        tgt_id;
    logic              cmd_out_valid, cmd_out_last;
    logic [7:0]        cmd_out_data;
    logic              tgt_resp_valid = 1'b1;
    logic [1:0]        tgt_resp = 2'd0;
    logic              irq, cause_fc, cause_bs, cause_dis, connected;
    logic [7:0]        stat_o;
    logic [2:0]        step;

    int checks = 0, fails = 0;
    bit finished = 1'b0;

    // bench FIFO model
    logic [7:0] fmem [64];
    int wr_ptr = 0;
    int rd_ptr = 0;
    assign fifo_count = FCNT_W'(wr_ptr - rd_ptr);
    assign fifo_rdata = fmem[rd_ptr % 64];

    function automatic logic [7:0] dma_byte(input int a);
        return 8'(a) ^ 8'(a >> 8) ^ 8'h3C;
    endfunction
    assign dma_rdata = dma_byte(int'(dma_addr));

    // capture of command bytes sent to the target
    logic [7:0] cap [64];
    int cap_n = 0;
    int last_at = -1;
    always @(posedge clk) begin
        if (fifo_flush) rd_ptr <= wr_ptr;
        else if (fifo_pop) rd_ptr <= rd_ptr + 1;
        if (cmd_out_valid) begin
            cap[cap_n % 64] <= cmd_out_data;
            cap_n <= cap_n + 1;
            if (cmd_out_last) last_at <= cap_n;
        end
    end

    selseq_top #(.FCNT_W(FCNT_W), .LEN_W(LEN_W)) uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        fmem[wr_ptr % 64] = b;
        wr_ptr++;
    endtask

    task automatic issue(input logic [1:0] k, input logic d, input logic [7:0] lo, input logic [7:0] mid);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = k; cmd_dma = d; cnt_lo = lo; cnt_mid = mid; sel_id = 3'd5;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(busy == 0 && irq == 0 && step == 0 && stat_o == 0 && connected == 0
            && cause_fc == 0 && cause_bs == 0 && cause_dis == 0, "R11 reset", int'(stat_o), 0);
    endtask

    task automatic t_plain_fifo();
        int base = cap_n;
        for (int i = 0; i < 6; i++) push(8'h10 + 8'(i));
        tgt_resp = 2'd0;
        issue(2'd0, 1'b0, 8'd0, 8'd0);
        chk(tgt_id == 3'd5, "R2 target id", int'(tgt_id), 5);
        wait_idle();
        chk(cap_n - base == 6, "R6 byte count", cap_n - base, 6);
        for (int i = 0; i < 6; i++)
            chk(cap[(base + i) % 64] == 8'h10 + 8'(i), "R6 byte order", int'(cap[(base + i) % 64]), 'h10 + i);
        chk(last_at == base + 5, "R6 last marker", last_at, base + 5);
        chk(stat_o == 8'h83, "R8 R10 status phase", int'(stat_o), 'h83);
        chk(cause_fc && cause_bs && !cause_dis && step == 3'd4 && connected, "R8 causes", int'(step), 4);
    endtask

    task automatic t_atn_datain();
        int base = cap_n;
        push(8'h80);
        for (int i = 0; i < 4; i++) push(8'hA0 + 8'(i));
        tgt_resp = 2'd1;
        issue(2'd1, 1'b0, 8'd0, 8'd0);
        chk(irq == 0 && step == 0, "R1 clear on accept", int'(irq), 0);
        wait_idle();
        chk(cap_n - base == 4, "R2 identify not sent", cap_n - base, 4);
        chk(cap[base % 64] == 8'hA0, "R2 first command byte", int'(cap[base % 64]), 'hA0);
        chk(stat_o[2:0] == 3'd1, "R8 data-in phase", int'(stat_o[2:0]), 1);
    endtask

    task automatic t_atn3_dataout();
        int base = cap_n;
        push(8'hC0); push(8'h55); push(8'h66);
        push(8'h01); push(8'h02);
        tgt_resp = 2'd2;
        issue(2'd3, 1'b0, 8'd0, 8'd0);
        @(negedge clk);
        chk(stat_o[2:0] == 3'd6, "R2 message-out during fetch", int'(stat_o[2:0]), 6);
        wait_idle();
        chk(cap_n - base == 2, "R2 three message bytes", cap_n - base, 2);
        chk(cap[base % 64] == 8'h01, "R2 after three", int'(cap[base % 64]), 1);
        chk(stat_o[2:0] == 3'd0 && step == 3'd4, "R8 data-out phase", int'(stat_o[2:0]), 0);
    endtask

    task automatic t_stop();
        int base = cap_n;
        push(8'h80); push(8'h11); push(8'h22);
        issue(2'd2, 1'b0, 8'd0, 8'd0);
        wait_idle();
        chk(cap_n == base, "R5 no command bytes", cap_n - base, 0);
        chk(stat_o == 8'h86 && step == 3'd1 && cause_fc && cause_bs && connected, "R5 stop result", int'(stat_o), 'h86);
        chk(fifo_count == 5'd2 && fifo_rdata == 8'h11, "R5 fifo kept", int'(fifo_count), 2);
        rd_ptr = wr_ptr;
    endtask

    task automatic t_bad_ident(input logic [7:0] b, input string tag);
        int base = cap_n;
        push(b); push(8'h12); push(8'h34);
        tgt_resp = 2'd0;
        issue(2'd1, 1'b0, 8'd0, 8'd0);
        wait_idle();
        chk(cap_n == base, {tag, " no command bytes"}, cap_n - base, 0);
        chk(irq && cause_dis && !cause_fc && step == 0 && !connected, {tag, " disconnect"}, int'(step), 0);
        chk(fifo_count == 0, {tag, " flushed"}, int'(fifo_count), 0);
    endtask

    task automatic t_absent();
        int base = cap_n;
        push(8'h80); push(8'h12);
        tgt_present = 1'b0;
        issue(2'd1, 1'b0, 8'd0, 8'd0);
        wait_idle();
        tgt_present = 1'b1;
        chk(irq && cause_dis && step == 0 && !connected, "R4 absent disconnect", int'(cause_dis), 1);
        chk(fifo_count == 0 && cap_n == base, "R4 flushed, nothing sent", int'(fifo_count), 0);
    endtask

    task automatic t_dma_small();
        int base = cap_n;
        tgt_resp = 2'd0;
        issue(2'd0, 1'b1, 8'd5, 8'd0);
        chk(stat_o[4] == 1'b0, "R1 tc cleared", int'(stat_o[4]), 0);
        wait_idle();
        chk(cap_n - base == 5, "R7 length", cap_n - base, 5);
        for (int i = 0; i < 5; i++)
            chk(cap[(base + i) % 64] == dma_byte(i), "R7 dma bytes", int'(cap[(base + i) % 64]), int'(dma_byte(i)));
        chk(stat_o == 8'h93, "R7 R10 terminal count", int'(stat_o), 'h93);
    endtask

    task automatic t_dma_mid();
        int base = cap_n;
        issue(2'd0, 1'b1, 8'd2, 8'd1);
        wait_idle();
        chk(cap_n - base == 258, "R7 middle byte weight", cap_n - base, 258);
    endtask

    task automatic t_dma_zero();
        int base = cap_n;
        issue(2'd0, 1'b1, 8'd0, 8'd0);
        wait_idle();
        chk(cap_n - base == 65536, "R7 zero count", cap_n - base, 65536);
        chk(last_at == base + 65535, "R7 zero count last", last_at - base, 65535);
        chk(stat_o[4] == 1'b1, "R7 tc after full", int'(stat_o[4]), 1);
    endtask

    task automatic t_reject();
        push(8'h2A);
        tgt_resp = 2'd3;
        issue(2'd0, 1'b0, 8'd0, 8'd0);
        wait_idle();
        chk(irq && cause_dis && !cause_fc && step == 0 && !connected, "R9 failed selection", int'(step), 0);
        chk(fifo_count == 0, "R9 flushed", int'(fifo_count), 0);
    endtask

    task automatic t_busy_ignore();
        int base = cap_n;
        push(8'h71); push(8'h72);
        tgt_resp_valid = 1'b0;
        tgt_resp = 2'd1;
        issue(2'd0, 1'b0, 8'd0, 8'd0);
        repeat (5) @(negedge clk);
        chk(busy == 1'b1 && irq == 1'b0, "R1 busy while waiting", int'(busy), 1);
        push(8'h80); push(8'h99);
        issue(2'd2, 1'b0, 8'd0, 8'd0);
        repeat (3) @(negedge clk);
        chk(fifo_count == 5'd2, "R1 second command ignored", int'(fifo_count), 2);
        tgt_resp_valid = 1'b1;
        wait_idle();
        chk(step == 3'd4 && stat_o[2:0] == 3'd1, "R1 first command result", int'(step), 4);
        chk(cap_n - base == 2, "R1 byte count", cap_n - base, 2);
        rd_ptr = wr_ptr;
        tgt_resp = 2'd0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_plain_fifo();
        t_atn_datain();
        t_atn3_dataout();
        t_stop();
        t_bad_ident(8'h81, "R3 lun");
        t_bad_ident(8'h40, "R3 header");
        t_absent();
        t_dma_small();
        t_dma_mid();
        t_dma_zero();
        t_reject();
        t_busy_ignore();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule